// File: doc/BRIEF.md
# External Memory Access Sequencer

This block sits between a processor core and a single external memory bus. At the start of an instruction the core may present up to three memory references at once: one to X data space, one to Y data space and one to program space. Each reference carries an address, a write word, a write flag and a flag saying whether the target lies outside the chip. References to on-chip memory are served elsewhere and leave the external bus untouched. The references that go off-chip are placed on the bus one after another, X before Y before program, because the bus carries only one word per transfer.

Each transfer holds its address, space selects and strobe for one cycle plus a number of wait states. That number is read from a configuration input at the moment the transfer is launched. While any transfer is on the bus the stall output holds the core. Read data is captured in the last cycle of its transfer and returned with a one-cycle valid pulse for the port that asked for it. A combined X and Y reference, or a double-word reference split into an X half and a Y half, therefore takes two transfers.

Top module: `ext_mem_seq`

## Requirements
- R1: At most one external transfer is on the bus at any time; each external reference of an instruction gets its own transfer, one after another with no idle cycle between them.
- R2: External references of one instruction go out in the fixed order X, then Y, then program.
- R3: A transfer holds its address, selects and strobe for W+1 cycles, where W is the value of `wait_cfg` in the cycle the transfer is launched. W = 0 gives a one-cycle transfer, and a later change of `wait_cfg` affects only later transfers.
- R4: `stall` rises in the cycle after the accepted `start` and stays high for exactly the sum of W+1 over the external transfers of that instruction.
- R5: When X and Y both point off-chip, which is a double-word or XY reference, the instruction takes two transfers: the X word first, then the Y word.
- R6: Space selects per transfer, written as {`sel_prog`,`sel_data`,`sel_ydata`}: program = 3'b100, X data = 3'b010, Y data = 3'b011.
- R7: An on-chip reference causes no change on the address, data, strobe or select outputs. An instruction whose references are all on-chip leaves `stall` low and the pins at their previous values.
- R8: `ext_rd_n` and `ext_wr_n` are active low and never low together. While `ext_wr_n` is low, `ext_doe` is 1 and `ext_dout` carries the write word. Both strobes are high and `ext_doe` is 0 when no transfer is active.
- R9: For a read, `ext_din` is sampled at the clock edge that ends the transfer's last cycle. In the next cycle `rdata` holds that word and exactly one of `x_rvalid`/`y_rvalid`/`p_rvalid` is high, for one cycle. Writes produce no valid pulse.
- R10: `start` is ignored while `stall` is high; requests presented then do not change the running sequence.
- R11: After reset: both strobes high, `ext_doe` 0, `ext_addr` and `ext_dout` zero, all selects 0, `stall` 0, all valids 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Instruction begins; requests are sampled when stall is low |
| wait_cfg | input | 4 | Wait states per transfer, sampled at launch |
| x_req | input | 1 | X data reference present |
| x_ext | input | 1 | X reference targets external memory |
| x_we | input | 1 | X reference is a write |
| x_addr | input | 16 | X address |
| x_wdata | input | 24 | X write word |
| y_req | input | 1 | Y data reference present |
| y_ext | input | 1 | Y reference targets external memory |
| y_we | input | 1 | Y reference is a write |
| y_addr | input | 16 | Y address |
| y_wdata | input | 24 | Y write word |
| p_req | input | 1 | Program reference present |
| p_ext | input | 1 | Program reference targets external memory |
| p_we | input | 1 | Program reference is a write |
| p_addr | input | 16 | Program address |
| p_wdata | input | 24 | Program write word |
| ext_din | input | 24 | Data bus input from external memory |
| ext_addr | output | 16 | External address bus |
| ext_dout | output | 24 | Data bus output word |
| ext_doe | output | 1 | Data bus output enable |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| sel_prog | output | 1 | Program space selected |
| sel_data | output | 1 | Data space selected |
| sel_ydata | output | 1 | Y data space (1) versus X data space (0) |
| stall | output | 1 | Core hold while transfers are pending |
| rdata | output | 24 | Returned read word |
| x_rvalid | output | 1 | rdata belongs to the X reference |
| y_rvalid | output | 1 | rdata belongs to the Y reference |
| p_rvalid | output | 1 | rdata belongs to the program reference |

## Verification
A corrupted pending mask or a wrong priority pick shows at once as a wrong address or select pattern in the first cycle of the affected transfer. A wait counter that is off by one stretches or cuts a transfer, so the address moves one cycle early or late and `stall` drops at the wrong cycle. Losing the read flag of the active transfer shows one cycle after that transfer as a missing or misdirected valid pulse with stale data. The bench compares every bus cycle of every instruction against a model built from the request list, so any such fault is reported in the cycle where it first appears.

// File: rtl/ems_pkg.sv
// Shared constants and types of the external memory access sequencer.
// Assumes three sources whose index is also their bus priority (0 highest).
package ems_pkg;
    localparam int NSRC  = 3;
    localparam int SRC_X = 0;
    localparam int SRC_Y = 1;
    localparam int SRC_P = 2;

    typedef struct packed {
        logic prog;
        logic data;
        logic ydat;
    } space_t;

    // Space-select pattern for a source index.
    function automatic space_t space_of(input logic [1:0] idx);
        space_t s;
        s.prog = (idx == 2'(SRC_P));
        s.data = (idx != 2'(SRC_P));
        s.ydat = (idx == 2'(SRC_Y));
        return s;
    endfunction
endpackage

// File: rtl/ems_prio_pick.sv
// Fixed-priority picker: grants the lowest-index set bit of the mask.
// Assumes bit 0 has the highest priority. Purely combinational.
module ems_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] mask,
    output logic [N-1:0] grant,
    output logic         any
);
    // Walk upward and keep the first request found.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any = |mask;
    end

    // Guard the grant against the mask that produced it.
    always_comb begin
        AST_GRANT_ONEHOT: assert ($isunknown(mask) || $onehot0(grant));          // R1
        AST_GRANT_IN_MASK: assert ($isunknown(mask) || ((grant & ~mask) == '0)); // R2
    end
endmodule

// File: rtl/ems_wait_timer.sv
// Wait-state down-counter for one bus transfer.
// Assumes load and run never need to act together (load wins).
// last is high in the final cycle of the running transfer.
module ems_wait_timer #(
    parameter int WSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [WSW-1:0] load_val,
    input  logic           run,
    output logic           last
);
    logic [WSW-1:0] cnt;

    // Load the wait count at launch, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/ems_bus_regs.sv
// Output registers of the external bus: address, data, strobes, selects.
// Assumes load and done_i are never high together. Pins only change on
// load (new transfer) or done_i (strobes released); otherwise they hold.
module ems_bus_regs #(
    parameter int AW = 16,
    parameter int DW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            done_i,
    input  logic [AW-1:0]   ld_addr,
    input  logic [DW-1:0]   ld_wdata,
    input  logic            ld_we,
    input  ems_pkg::space_t ld_space,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   dout,
    output logic            doe,
    output logic            rd_n,
    output logic            wr_n,
    output ems_pkg::space_t space
);
    // Register the pins of a new transfer or release the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            dout  <= '0;
            doe   <= 1'b0;
            rd_n  <= 1'b1;
            wr_n  <= 1'b1;
            space <= '0;
        end else if (load) begin
            addr  <= ld_addr;
            space <= ld_space;
            if (ld_we) begin
                dout <= ld_wdata;
                doe  <= 1'b1;
                wr_n <= 1'b0;
                rd_n <= 1'b1;
            end else begin
                doe  <= 1'b0;
                rd_n <= 1'b0;
                wr_n <= 1'b1;
            end
        end else if (done_i) begin
            rd_n <= 1'b1;
            wr_n <= 1'b1;
            doe  <= 1'b0;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));                                                      // R8
    AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> doe);                                                          // R8
endmodule

// File: rtl/ext_mem_seq.sv
// External memory access sequencer (top).
// On an accepted start it takes the external references of one instruction,
// launches them one per transfer in priority order X, Y, program, adds
// wait_cfg wait states to each, holds stall meanwhile and returns read data
// with a per-source valid pulse. Assumes the core keeps start low, or
// ignores its effect, while stall is high.
module ext_mem_seq #(
    parameter int AW  = 16,
    parameter int DW  = 24,
    parameter int WSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [WSW-1:0] wait_cfg,
    input  logic           x_req,
    input  logic           x_ext,
    input  logic           x_we,
    input  logic [AW-1:0]  x_addr,
    input  logic [DW-1:0]  x_wdata,
    input  logic           y_req,
    input  logic           y_ext,
    input  logic           y_we,
    input  logic [AW-1:0]  y_addr,
    input  logic [DW-1:0]  y_wdata,
    input  logic           p_req,
    input  logic           p_ext,
    input  logic           p_we,
    input  logic [AW-1:0]  p_addr,
    input  logic [DW-1:0]  p_wdata,
    input  logic [DW-1:0]  ext_din,
    output logic [AW-1:0]  ext_addr,
    output logic [DW-1:0]  ext_dout,
    output logic           ext_doe,
    output logic           ext_rd_n,
    output logic           ext_wr_n,
    output logic           sel_prog,
    output logic           sel_data,
    output logic           sel_ydata,
    output logic           stall,
    output logic [DW-1:0]  rdata,
    output logic           x_rvalid,
    output logic           y_rvalid,
    output logic           p_rvalid
);
    import ems_pkg::*;

    localparam int NS = NSRC;

    logic [AW-1:0] in_addr  [NS];
    logic [DW-1:0] in_wdata [NS];
    logic [NS-1:0] in_we;
    logic [NS-1:0] in_mask;
    logic [AW-1:0] st_addr  [NS];
    logic [DW-1:0] st_wdata [NS];
    logic [NS-1:0] st_we;

    logic          busy;
    logic [NS-1:0] pend;
    logic [NS-1:0] cur;
    logic          cur_we;
    logic          accept, finish, launch, last;
    logic [NS-1:0] src_mask, grant;
    logic          src_any;
    logic [1:0]    gi;
    logic [AW-1:0] l_addr;
    logic [DW-1:0] l_wdata;
    logic          l_we;
    logic [NS-1:0] rvalid;
    space_t        pin_space;

    assign in_addr[SRC_X]  = x_addr;
    assign in_addr[SRC_Y]  = y_addr;
    assign in_addr[SRC_P]  = p_addr;
    assign in_wdata[SRC_X] = x_wdata;
    assign in_wdata[SRC_Y] = y_wdata;
    assign in_wdata[SRC_P] = p_wdata;
    assign in_we           = {p_we, y_we, x_we};
    assign in_mask         = {p_req & p_ext, y_req & y_ext, x_req & x_ext};

    assign accept   = start && !busy;
    assign finish   = busy && last;
    assign src_mask = accept ? in_mask : (finish ? pend : '0);
    assign launch   = src_any;

    ems_prio_pick #(.N(NS)) u_pick (
        .mask  (src_mask),
        .grant (grant),
        .any   (src_any)
    );

    // Index of the granted source.
    always_comb begin
        gi = '0;
        for (int i = 0; i < NS; i++)
            if (grant[i]) gi = 2'(i);
    end

    // Bundle of the transfer to launch: live inputs at accept, else stored.
    always_comb begin
        if (accept) begin
            l_addr  = in_addr[gi];
            l_wdata = in_wdata[gi];
            l_we    = in_we[gi];
        end else begin
            l_addr  = st_addr[gi];
            l_wdata = st_wdata[gi];
            l_we    = st_we[gi];
        end
    end

    // Per-source holding registers, filled when an instruction is accepted.
    for (genvar s = 0; s < NS; s++) begin : g_store
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_addr[s]  <= '0;
                st_wdata[s] <= '0;
                st_we[s]    <= 1'b0;
            end else if (accept) begin
                st_addr[s]  <= in_addr[s];
                st_wdata[s] <= in_wdata[s];
                st_we[s]    <= in_we[s];
            end
        end
    end

    // Sequencer state: active transfer, its source and what remains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            pend   <= '0;
            cur    <= '0;
            cur_we <= 1'b0;
        end else if (launch) begin
            busy   <= 1'b1;
            cur    <= grant;
            cur_we <= l_we;
            pend   <= src_mask & ~grant;
        end else if (finish) begin
            busy   <= 1'b0;
            pend   <= '0;
        end
    end

    ems_wait_timer #(.WSW(WSW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (wait_cfg),
        .run      (busy),
        .last     (last)
    );

    ems_bus_regs #(.AW(AW), .DW(DW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .done_i   (finish && !launch),
        .ld_addr  (l_addr),
        .ld_wdata (l_wdata),
        .ld_we    (l_we),
        .ld_space (space_of(gi)),
        .addr     (ext_addr),
        .dout     (ext_dout),
        .doe      (ext_doe),
        .rd_n     (ext_rd_n),
        .wr_n     (ext_wr_n),
        .space    (pin_space)
    );

    // Capture read data at the end of a read and pulse its source's valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= '0;
            rdata  <= '0;
        end else begin
            rvalid <= (finish && !cur_we) ? cur : '0;
            if (finish && !cur_we)
                rdata <= ext_din;
        end
    end

    assign stall     = busy;
    assign sel_prog  = pin_space.prog;
    assign sel_data  = pin_space.data;
    assign sel_ydata = pin_space.ydat;
    assign x_rvalid  = rvalid[SRC_X];
    assign y_rvalid  = rvalid[SRC_Y];
    assign p_rvalid  = rvalid[SRC_P];

    AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable(ext_addr) && $stable(pin_space));                    // R7
    AST_STALL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        stall == (!ext_rd_n || !ext_wr_n));                                      // R4
    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> $stable(ext_addr) && $stable(ext_rd_n));             // R3
    AST_VALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({p_rvalid, y_rvalid, x_rvalid}));                               // R9
    AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);                                               // R10
endmodule

// File: tb/ext_mem_seq_test.sv
`timescale 1ns/1ps
module ext_mem_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  wait_cfg = '0;
    logic [2:0]  b_req = '0, b_ext = '0, b_we = '0;
    logic [15:0] b_addr [3];
    logic [23:0] b_wdata [3];
    logic [23:0] ext_din;
    logic [15:0] ext_addr;
    logic [23:0] ext_dout, rdata;
    logic        ext_doe, ext_rd_n, ext_wr_n, sel_prog, sel_data, sel_ydata, stall;
    logic        x_rvalid, y_rvalid, p_rvalid;
    int          n_chk = 0, n_err = 0;
    logic [15:0] prev_addr = '0;

    always #2.5 clk = ~clk;

    ext_mem_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wait_cfg(wait_cfg),
        .x_req(b_req[0]), .x_ext(b_ext[0]), .x_we(b_we[0]), .x_addr(b_addr[0]), .x_wdata(b_wdata[0]),
        .y_req(b_req[1]), .y_ext(b_ext[1]), .y_we(b_we[1]), .y_addr(b_addr[1]), .y_wdata(b_wdata[1]),
        .p_req(b_req[2]), .p_ext(b_ext[2]), .p_we(b_we[2]), .p_addr(b_addr[2]), .p_wdata(b_wdata[2]),
        .ext_din(ext_din), .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .sel_prog(sel_prog), .sel_data(sel_data),
        .sel_ydata(sel_ydata), .stall(stall), .rdata(rdata),
        .x_rvalid(x_rvalid), .y_rvalid(y_rvalid), .p_rvalid(p_rvalid)
    );

    // Memory model: read word is a fixed function of the address.
    function automatic logic [23:0] mem_word(input logic [15:0] a);
        return {a, a[15:8]} ^ 24'h5A3C96;
    endfunction

    // Expected selects per R6.
    function automatic logic [2:0] sel_exp(input int p);
        return (p == 2) ? 3'b100 : ((p == 1) ? 3'b011 : 3'b010);
    endfunction

    assign ext_din = mem_word(ext_addr);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One instruction: wf = wait for first transfer, wr = wait for the rest.
    task automatic instr(input logic [2:0] rq, input logic [2:0] ex, input logic [2:0] we,
                         input logic [3:0] wf, input logic [3:0] wr, input bit junk);
        int lst[3];
        int n = 0;
        logic [15:0] e_addr[3];
        logic [23:0] e_wd[3];
        logic [2:0]  e_we;
        logic [2:0]  exp_v = '0;
        logic [23:0] exp_d = '0;
        for (int i = 0; i < 3; i++) begin
            b_addr[i]  = 16'($urandom);
            b_wdata[i] = 24'($urandom);
            e_addr[i]  = b_addr[i];
            e_wd[i]    = b_wdata[i];
            if (rq[i] && ex[i]) begin lst[n] = i; n++; end
        end
        b_req = rq; b_ext = ex; b_we = we; e_we = we;
        wait_cfg = wf;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (junk && n > 0) begin
            start = 1'b1;
            b_req = 3'b111; b_ext = 3'b111; b_we = ~we;
            for (int i = 0; i < 3; i++) b_addr[i] = 16'($urandom);
        end
        for (int k = 0; k < n; k++) begin
            int p = lst[k];
            int w = (k == 0) ? int'(wf) : int'(wr);
            for (int c = 0; c <= w; c++) begin
                chk("R4 stall high", stall, 1);
                chk("R1 R2 R5 R10 address", ext_addr, e_addr[p]);
                chk("R8 strobes", {ext_rd_n, ext_wr_n}, e_we[p] ? 2'b10 : 2'b01);
                chk("R6 selects", {sel_prog, sel_data, sel_ydata}, sel_exp(p));
                if (e_we[p]) chk("R8 write data", {ext_doe, ext_dout}, {1'b1, e_wd[p]});
                else         chk("R8 oe off on read", ext_doe, 0);
                chk("R9 valid", {p_rvalid, y_rvalid, x_rvalid}, exp_v);
                if (exp_v != 0) chk("R9 rdata", rdata, exp_d);
                exp_v = '0;
                if (c == w && !e_we[p]) begin
                    exp_v = 3'(1 << p);
                    exp_d = mem_word(e_addr[p]);
                end
                if (k == 0 && c == 0) wait_cfg = wr;   // R3: later launches use new value
                if (k == n - 1 && c == w) start = 1'b0;
                @(negedge clk);
            end
        end
        start = 1'b0;
        if (n > 0) prev_addr = e_addr[lst[n-1]];
        chk("R4 R7 stall low after", stall, 0);
        chk("R8 strobes idle", {ext_rd_n, ext_wr_n, ext_doe}, 3'b110);
        chk("R7 address holds", ext_addr, prev_addr);
        chk("R9 final valid", {p_rvalid, y_rvalid, x_rvalid}, exp_v);
        if (exp_v != 0) chk("R9 final rdata", rdata, exp_d);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin b_addr[i] = '0; b_wdata[i] = '0; end
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 strobes/oe", {ext_rd_n, ext_wr_n, ext_doe}, 3'b110);
        chk("R11 addr/dout", {ext_addr, ext_dout}, 0);
        chk("R11 selects/stall", {sel_prog, sel_data, sel_ydata, stall}, 0);
        chk("R11 valids", {p_rvalid, y_rvalid, x_rvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        instr(3'b111, 3'b111, 3'b000, 4'd0, 4'd0, 0);   // R2 all three, single cycle
        instr(3'b111, 3'b000, 3'b000, 4'd2, 4'd2, 0);   // R7 all internal
        instr(3'b111, 3'b110, 3'b010, 4'd1, 4'd1, 0);   // R7 X internal, Y write, P read
        instr(3'b011, 3'b011, 3'b000, 4'd2, 4'd2, 0);   // R5 double word read
        instr(3'b011, 3'b011, 3'b011, 4'd3, 4'd3, 0);   // R5 R8 double word write
        instr(3'b101, 3'b101, 3'b000, 4'd1, 4'd4, 0);   // R3 wait change mid-instruction
        instr(3'b100, 3'b100, 3'b000, 4'd15, 4'd15, 0); // R3 maximum wait
        instr(3'b111, 3'b111, 3'b101, 4'd1, 4'd1, 1);   // R10 start while stalled
        instr(3'b010, 3'b010, 3'b000, 4'd0, 4'd0, 0);   // R6 Y alone
        for (int t = 0; t < 150; t++) begin
            logic [3:0] w1 = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 4);
            logic [3:0] w2 = ($urandom % 4 == 0) ? 4'($urandom % 6) : w1;
            instr(3'($urandom), 3'($urandom), 3'($urandom), w1, w2, ($urandom % 5) == 0);
            if ($urandom % 3 == 0) @(negedge clk);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R4 watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule